// File: doc/BRIEF.md
# Clock Generator PLL Register Pair

This block is the software-visible register pair of a clock generator. One register controls the PLL: it holds the PLL enable and the bit that selects the VCO as the source of the base clock. The other register controls loop bandwidth: it holds the automatic-bandwidth bit and the acquisition/tracking bit, and it shows the lock status of the PLL. A simple synchronous port serves both registers. Writes take effect on the clock edge, and reads are combinational from the register state and the PLL status inputs.

The block enforces two hardware rules. First, the base clock can never be switched to the VCO while the PLL is off, and the PLL can never be switched off while the VCO drives the base clock. Second, the acquisition bit and the lock bit change meaning with the bandwidth mode. In automatic mode both are read-only and mirror the PLL. In manual mode the acquisition bit is writable and drives the PLL mode directly, and the lock bit reads 0. A stop request drops the VCO selection at once.

Top module: `clkgen_regs`

## Requirements
- R1: After reset, the control register (address 0x1C) reads 0x0F, the bandwidth register (address 0x1D) reads 0x00, and `pll_en_o`, `vco_sel_o` and `track_mode_o` are 0.
- R2: In the control register, bits 3:0 always read 1 and bits 7:6 always read 0. Writes to these bits have no effect.
- R3: Control bit 5 is the PLL enable and drives `pll_en_o`. While `vco_sel_o` is 0, a write sets or clears it.
- R4: A control write that clears bit 5 while the select bit is 1 leaves the PLL enable at 1.
- R5: Control bit 4 is the VCO select and drives `vco_sel_o`. A write can set it only if the PLL enable was already 1 before that write. Starting from a disabled PLL, two writes are therefore needed.
- R6: A high `stop_req_i` clears the VCO select at the next edge. This takes priority over a write in the same cycle.
- R7: Bandwidth bit 7 (automatic mode) and bit 4 (crystal-check flag) are read/write and reset to 0. Bandwidth bits 3:0 read 0.
- R8: When the automatic bit is 1, bit 6 reads `pll_lock_i`, bit 5 reads `pll_track_i`, and `track_mode_o` follows `pll_track_i`. Writes to bits 6 and 5 are ignored; whether bit 5 is ignored depends on the automatic bit before the write.
- R9: When the automatic bit is 0, bit 6 reads 0. Bit 5 is a stored read/write bit that drives `track_mode_o` (1 = tracking), and it keeps its value across automatic periods.
- R10: Reads of any other address return 0, and writes to any other address change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| addr_i | input | ADDR_W | Register address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| pll_lock_i | input | 1 | PLL lock status |
| pll_track_i | input | 1 | PLL tracking status (1 = tracking) |
| stop_req_i | input | 1 | Stop request, clears the VCO select |
| pll_en_o | output | 1 | PLL enable |
| vco_sel_o | output | 1 | Base clock from VCO when 1 |
| track_mode_o | output | 1 | PLL tracking mode when 1 |

## Verification
A corrupted enable or select flop shows on `pll_en_o` and `vco_sel_o` at the edge after the write that caused it. The same error appears in the control read value in the same cycle. A wrong bandwidth state shows immediately on `track_mode_o` and on the combinational read of the bandwidth register, because the status inputs pass straight through in automatic mode. Each interlock case is therefore checked by reading back right after the single write that exercises it.

// File: rtl/clkgen_regs_pkg.sv
package clkgen_regs_pkg;
  localparam int DATA_W      = 8;
  localparam int CTL_EN_BIT  = 5;
  localparam int CTL_SEL_BIT = 4;
  localparam int BW_AUTO_BIT = 7;
  localparam int BW_LOCK_BIT = 6;
  localparam int BW_ACQ_BIT  = 5;
  localparam int BW_XLD_BIT  = 4;
  localparam logic [3:0] CTL_LOW_FILL = 4'hF;

  typedef struct packed {
    logic en;
    logic sel;
  } ctl_state_t;

  typedef struct packed {
    logic auto_bw;
    logic acq;
    logic xld;
  } bw_state_t;
endpackage

// File: rtl/clkgen_rst_sync.sv
module clkgen_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[i] <= 1'b0;
        else if (i == 0) chain_q[i] <= 1'b1;
        else chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign rst_sync_no = chain_q[STAGES-1];
endmodule

// File: rtl/clkgen_ctl_reg.sv
module clkgen_ctl_reg
  import clkgen_regs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       wr_en_bit_i,
  input  logic       wr_sel_bit_i,
  input  logic       stop_i,
  output ctl_state_t state_o
);
  ctl_state_t cur_q, nxt;
  logic       upd;

  assign upd = wr_i | stop_i;

  always_comb begin
    nxt = cur_q;
    if (wr_i) begin
      // enable may only fall while the VCO is not selected
      nxt.en  = wr_en_bit_i | cur_q.sel;
      // select may only rise once the PLL is already enabled
      nxt.sel = wr_sel_bit_i & cur_q.en;
    end
    if (stop_i) nxt.sel = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  cur_q <= '0;
    else if (upd) cur_q <= nxt;
  end

  assign state_o = cur_q;
endmodule

// File: rtl/clkgen_bw_reg.sv
module clkgen_bw_reg
  import clkgen_regs_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_i,
  input  logic      wr_auto_bit_i,
  input  logic      wr_acq_bit_i,
  input  logic      wr_xld_bit_i,
  input  logic      pll_track_i,
  output bw_state_t state_o,
  output logic      track_mode_o
);
  bw_state_t cur_q, nxt;

  always_comb begin
    nxt = cur_q;
    if (wr_i) begin
      nxt.auto_bw = wr_auto_bit_i;
      nxt.xld     = wr_xld_bit_i;
      // acquisition bit is writable only in manual mode
      if (!cur_q.auto_bw) nxt.acq = wr_acq_bit_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cur_q <= '0;
    else if (wr_i) cur_q <= nxt;
  end

  assign state_o      = cur_q;
  assign track_mode_o = cur_q.auto_bw ? pll_track_i : cur_q.acq;
endmodule

// File: rtl/clkgen_rd_mux.sv
module clkgen_rd_mux
  import clkgen_regs_pkg::*;
(
  input  logic              hit_ctl_i,
  input  logic              hit_bw_i,
  input  ctl_state_t        ctl_i,
  input  bw_state_t         bw_i,
  input  logic              pll_lock_i,
  input  logic              track_mode_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] ctl_word, bw_word;

  always_comb begin
    ctl_word              = '0;
    ctl_word[3:0]         = CTL_LOW_FILL;
    ctl_word[CTL_EN_BIT]  = ctl_i.en;
    ctl_word[CTL_SEL_BIT] = ctl_i.sel;

    bw_word               = '0;
    bw_word[BW_AUTO_BIT]  = bw_i.auto_bw;
    bw_word[BW_LOCK_BIT]  = bw_i.auto_bw & pll_lock_i;
    bw_word[BW_ACQ_BIT]   = track_mode_i;
    bw_word[BW_XLD_BIT]   = bw_i.xld;

    if (hit_ctl_i)     rdata_o = ctl_word;
    else if (hit_bw_i) rdata_o = bw_word;
    else               rdata_o = '0;
  end
endmodule

// File: rtl/clkgen_regs.sv
module clkgen_regs
  import clkgen_regs_pkg::*;
#(
  parameter int              ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h1C,
  parameter logic [ADDR_W-1:0] BW_ADDR   = 'h1D,
  parameter int              SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              pll_lock_i,
  input  logic              pll_track_i,
  input  logic              stop_req_i,
  output logic              pll_en_o,
  output logic              vco_sel_o,
  output logic              track_mode_o
);
  logic       rst_core_n;
  logic       hit_ctl, hit_bw;
  ctl_state_t ctl_st;
  bw_state_t  bw_st;
  logic       unused_wdata;

  assign unused_wdata = ^{wdata_i[BW_LOCK_BIT], wdata_i[3:0]};

  clkgen_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_core_n)
  );

  assign hit_ctl = (addr_i == CTRL_ADDR);
  assign hit_bw  = (addr_i == BW_ADDR);

  clkgen_ctl_reg u_ctl (
    .clk_i        (clk_i),
    .rst_ni       (rst_core_n),
    .wr_i         (wr_en_i & hit_ctl),
    .wr_en_bit_i  (wdata_i[CTL_EN_BIT]),
    .wr_sel_bit_i (wdata_i[CTL_SEL_BIT]),
    .stop_i       (stop_req_i),
    .state_o      (ctl_st)
  );

  clkgen_bw_reg u_bw (
    .clk_i         (clk_i),
    .rst_ni        (rst_core_n),
    .wr_i          (wr_en_i & hit_bw),
    .wr_auto_bit_i (wdata_i[BW_AUTO_BIT]),
    .wr_acq_bit_i  (wdata_i[BW_ACQ_BIT]),
    .wr_xld_bit_i  (wdata_i[BW_XLD_BIT]),
    .pll_track_i   (pll_track_i),
    .state_o       (bw_st),
    .track_mode_o  (track_mode_o)
  );

  clkgen_rd_mux u_rd (
    .hit_ctl_i    (hit_ctl),
    .hit_bw_i     (hit_bw),
    .ctl_i        (ctl_st),
    .bw_i         (bw_st),
    .pll_lock_i   (pll_lock_i),
    .track_mode_i (track_mode_o),
    .rdata_o      (rdata_o)
  );

  assign pll_en_o  = ctl_st.en;
  assign vco_sel_o = ctl_st.sel;
endmodule

// File: rtl/clkgen_regs_chk.sv
module clkgen_regs_chk #(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h1C,
  parameter logic [ADDR_W-1:0] BW_ADDR   = 'h1D
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        rdata_o,
  input logic              pll_lock_i,
  input logic              pll_track_i,
  input logic              stop_req_i,
  input logic              pll_en_o,
  input logic              vco_sel_o,
  input logic              track_mode_o
);
  // R4
  en_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vco_sel_o |=> pll_en_o);
  // R5
  sel_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vco_sel_o |-> pll_en_o);
  // R5
  sel_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vco_sel_o) |-> $past(pll_en_o));
  // R6
  stop_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_req_i |=> !vco_sel_o);
  // R2
  ctl_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == CTRL_ADDR) |-> (rdata_o[3:0] == 4'hF && rdata_o[7:6] == 2'b00));
  // R8
  auto_view_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == BW_ADDR && rdata_o[7]) |->
      (rdata_o[6] == pll_lock_i && rdata_o[5] == pll_track_i && track_mode_o == pll_track_i));
  // R9
  manual_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == BW_ADDR && !rdata_o[7]) |-> (!rdata_o[6] && rdata_o[5] == track_mode_o));
  // R10
  other_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != BW_ADDR && addr_i != CTRL_ADDR) |-> (rdata_o == 8'h00));
endmodule

bind clkgen_regs clkgen_regs_chk #(
  .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .BW_ADDR(BW_ADDR)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .addr_i       (addr_i),
  .rdata_o      (rdata_o),
  .pll_lock_i   (pll_lock_i),
  .pll_track_i  (pll_track_i),
  .stop_req_i   (stop_req_i),
  .pll_en_o     (pll_en_o),
  .vco_sel_o    (vco_sel_o),
  .track_mode_o (track_mode_o)
);

// File: tb/clkgen_regs_test.sv
`timescale 1ns/1ps
module clkgen_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_CTL = 8'h1C;
  localparam logic [7:0] A_BW  = 8'h1D;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [7:0] addr_i;
  logic       wr_en_i;
  logic [7:0] wdata_i;
  logic [7:0] rdata_o;
  logic       pll_lock_i, pll_track_i, stop_req_i;
  logic       pll_en_o, vco_sel_o, track_mode_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  clkgen_regs uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pll_lock_i(pll_lock_i),
    .pll_track_i(pll_track_i), .stop_req_i(stop_req_i), .pll_en_o(pll_en_o),
    .vco_sel_o(vco_sel_o), .track_mode_o(track_mode_o)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic stop);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1; stop_req_i = stop;
    @(negedge clk_i);
    wr_en_i = 1'b0; stop_req_i = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [7:0] a, input logic [7:0] exp);
    addr_i = a;
    #1;
    check(req, rdata_o, exp);
  endtask

  task automatic t_reset;
    rd_check("R1 ctl", A_CTL, 8'h0F);
    rd_check("R1 bw", A_BW, 8'h00);
    check("R1 outputs", {5'd0, pll_en_o, vco_sel_o, track_mode_o}, 8'h00);
  endtask

  task automatic t_ctrl_interlock;
    wr(A_CTL, 8'hFF, 1'b0);
    rd_check("R5 sel blocked, R2 fill", A_CTL, 8'h2F);
    check("R3 pll_en_o", {7'd0, pll_en_o}, 8'h01);
    check("R5 vco_sel_o low", {7'd0, vco_sel_o}, 8'h00);
    wr(A_CTL, 8'h30, 1'b0);
    rd_check("R5 second write", A_CTL, 8'h3F);
    check("R5 vco_sel_o high", {7'd0, vco_sel_o}, 8'h01);
    wr(A_CTL, 8'h00, 1'b0);
    rd_check("R4 en kept", A_CTL, 8'h2F);
    check("R4 pll_en_o", {7'd0, pll_en_o}, 8'h01);
    wr(A_CTL, 8'h00, 1'b0);
    rd_check("R3 en cleared", A_CTL, 8'h0F);
  endtask

  task automatic t_stop;
    wr(A_CTL, 8'h20, 1'b0);
    wr(A_CTL, 8'h30, 1'b0);
    @(negedge clk_i); stop_req_i = 1'b1;
    @(negedge clk_i); stop_req_i = 1'b0;
    rd_check("R6 stop clears sel", A_CTL, 8'h2F);
    check("R6 vco_sel_o", {7'd0, vco_sel_o}, 8'h00);
    wr(A_CTL, 8'h30, 1'b1);
    rd_check("R6 stop beats write", A_CTL, 8'h2F);
    wr(A_CTL, 8'h30, 1'b0);
    rd_check("R5 reselect", A_CTL, 8'h3F);
    wr(A_CTL, 8'h00, 1'b0);
    wr(A_CTL, 8'h00, 1'b0);
    rd_check("R3 off again", A_CTL, 8'h0F);
  endtask

  task automatic t_bw_manual;
    pll_lock_i = 1'b1; pll_track_i = 1'b0;
    wr(A_BW, 8'h30, 1'b0);
    rd_check("R9 manual acq, R7 xld", A_BW, 8'h30);
    check("R9 track_mode_o set", {7'd0, track_mode_o}, 8'h01);
    wr(A_BW, 8'h4F, 1'b0);
    rd_check("R7 low bits / R9 lock 0", A_BW, 8'h00);
    check("R9 track_mode_o clear", {7'd0, track_mode_o}, 8'h00);
  endtask

  task automatic t_bw_auto;
    pll_lock_i = 1'b1; pll_track_i = 1'b0;
    wr(A_BW, 8'hA0, 1'b0);
    rd_check("R8 lock shown, acq from pll", A_BW, 8'hC0);
    check("R8 track_mode_o", {7'd0, track_mode_o}, 8'h00);
    pll_track_i = 1'b1;
    rd_check("R8 acq follows pll", A_BW, 8'hE0);
    check("R8 track_mode_o follows", {7'd0, track_mode_o}, 8'h01);
    pll_lock_i = 1'b0;
    rd_check("R8 lock follows", A_BW, 8'hA0);
    wr(A_BW, 8'h90, 1'b0);
    rd_check("R8 acq write ignored, R7 xld", A_BW, 8'hB0);
    pll_track_i = 1'b0;
    rd_check("R8 acq from pll again", A_BW, 8'h90);
    pll_lock_i = 1'b1;
    wr(A_BW, 8'h00, 1'b0);
    rd_check("R9 stored acq kept", A_BW, 8'h20);
    check("R9 track_mode_o stored", {7'd0, track_mode_o}, 8'h01);
  endtask

  task automatic t_addr_decode;
    wr(8'h1E, 8'hFF, 1'b0);
    rd_check("R10 ctl untouched", A_CTL, 8'h0F);
    rd_check("R10 bw untouched", A_BW, 8'h20);
    rd_check("R10 other read 1E", 8'h1E, 8'h00);
    rd_check("R10 other read 00", 8'h00, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; addr_i = '0; wr_en_i = 1'b0; wdata_i = '0;
    pll_lock_i = 1'b0; pll_track_i = 1'b0; stop_req_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    t_reset();
    t_ctrl_interlock();
    t_stop();
    t_bw_manual();
    t_bw_auto();
    t_addr_decode();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule